// File: doc/BRIEF.md
# Shadow-Tag Prefetch Configuration Selector

This block tunes a cache prefetcher while the program runs. Two tag directories see the same access stream. The real L2 directory is served by the live prefetcher. A shadow directory holds tags but no data, and is served by a second prefetcher that runs a trial configuration. The selector takes event pulses from both sides: hits, late prefetches and misses. At the end of each scoring window it gives each side a fitness score. When the trial side has outscored the live side often enough in a row, the selector hands the trial settings to the live prefetcher.

A window closes on the cycle in which a fixed number of real-L2 misses since the last evaluation has been reached. A side's fitness is its hit count, minus its late-prefetch count, minus a bandwidth penalty. The penalty grows with the side's misses and is reduced by the elapsed cycles, and it never drops below zero. Whether the trial side wins or loses, every evaluation draws a new trial configuration from a 16-bit LFSR, so the parameter space keeps being explored. The shadow tag contents stay untouched throughout.

A configuration has three fields: prefetch degree, prefetch distance and a region-size code. At reset the live prefetcher is off.

Top module: `pfsel_top`

## Requirements
- R1: After reset the live degree, distance and region code are all 0. The shadow fields are the draw of the LFSR seed.
- R2: An evaluation happens on a cycle with a real miss when that miss is the WINDOW_MISSES-th real miss since the previous evaluation (or since reset). Its results appear at the outputs on the next cycle. In any other cycle the outputs keep their values, whatever events arrive.
- R3: For each side, fitness = hits − late prefetches − penalty, as a signed number. The events of the evaluation cycle itself count in the totals.
- R4: penalty = max(0, misses×MISS_K − cycles/BW_THRESH), using integer division. Here "cycles" counts the clock cycles of the window, including the evaluation cycle. For the live side, "misses" is its real-miss count.
- R5: The trial side wins an evaluation only if its fitness is strictly greater than the live fitness; a tie is a loss. After NEED_WINS consecutive wins, the live configuration becomes the trial configuration that was scored in that window.
- R6: The win streak returns to zero after any loss and after every adoption.
- R7: Every evaluation advances the LFSR once. The step is a right shift, XORed with 0xB400 when the bit shifted out is 1. The new trial configuration is then read from the new LFSR value: degree = bits[4:0] mod 17, distance = bits[9:5] mod 17, region code = bits[13:10] mod 11. Region code c selects 4 KB << c.
- R8: All per-side counters and the cycle counter restart from zero after each evaluation, so each window is scored on its own events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| real_hit | input | 1 | Hit pulse from the real L2 directory |
| real_late | input | 1 | Late-prefetch pulse from the real side |
| real_miss | input | 1 | Real L2 miss pulse; also advances the window |
| shadow_hit | input | 1 | Hit pulse from the shadow directory |
| shadow_late | input | 1 | Late-prefetch pulse from the shadow side |
| shadow_miss | input | 1 | Miss pulse from the shadow directory |
| live_degree | output | 5 | Live prefetch degree (0..16) |
| live_distance | output | 5 | Live prefetch distance (0..16) |
| live_region | output | 4 | Live region-size code (0..10) |
| shadow_degree | output | 5 | Trial prefetch degree |
| shadow_distance | output | 5 | Trial prefetch distance |
| shadow_region | output | 4 | Trial region-size code |

## Verification
The bench builds the block with WINDOW_MISSES = 4, NEED_WINS = 2, MISS_K = 4 and BW_THRESH = 8. With a window of four misses, hundreds of evaluations fit in a short run, and each one exercises the LFSR redraw. Requiring two wins makes a streak that breaks on a loss observable, which a value of one cannot show. The small threshold lets a 160-cycle window drive the penalty to its zero clamp, while a dense four-cycle window leaves it large.

// File: rtl/pfsel_pkg.sv
package pfsel_pkg;

    localparam int DEG_MAX      = 16;
    localparam int DIST_MAX     = 16;
    localparam int REGION_CODES = 11;

    localparam int DEG_W  = $clog2(DEG_MAX + 1);
    localparam int DIST_W = $clog2(DIST_MAX + 1);
    localparam int REG_W  = $clog2(REGION_CODES);

    localparam logic [15:0] LFSR_MASK = 16'hB400;

    typedef struct packed {
        logic [DEG_W-1:0]  degree;
        logic [DIST_W-1:0] distance;
        logic [REG_W-1:0]  region;
    } pf_cfg_t;

    // One Galois step, shifting right
    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
    endfunction

    // Fold LFSR fields into the legal ranges
    function automatic pf_cfg_t cfg_from_rand(input logic [15:0] s);
        pf_cfg_t c;
        c.degree   = DEG_W'(32'(s[4:0]) % (DEG_MAX + 1));
        c.distance = DIST_W'(32'(s[9:5]) % (DIST_MAX + 1));
        c.region   = REG_W'(32'(s[13:10]) % REGION_CODES);
        return c;
    endfunction

endpackage

// File: rtl/pfsel_evt_ctr.sv
module pfsel_evt_ctr #(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           hit_i,
    input  logic           late_i,
    input  logic           miss_i,
    output logic [CNT_W:0] hit_tot_o,
    output logic [CNT_W:0] late_tot_o,
    output logic [CNT_W:0] miss_tot_o
);

    typedef struct packed {
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] late;
        logic [CNT_W-1:0] miss;
    } ctr_t;

    ctr_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else begin
            if (hit_i  && !(&cnt_q.hits)) cnt_d.hits = cnt_q.hits + 1'b1;
            if (late_i && !(&cnt_q.late)) cnt_d.late = cnt_q.late + 1'b1;
            if (miss_i && !(&cnt_q.miss)) cnt_d.miss = cnt_q.miss + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Totals include the event of the current cycle
    assign hit_tot_o  = {1'b0, cnt_q.hits} + (CNT_W+1)'(hit_i);
    assign late_tot_o = {1'b0, cnt_q.late} + (CNT_W+1)'(late_i);
    assign miss_tot_o = {1'b0, cnt_q.miss} + (CNT_W+1)'(miss_i);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/pfsel_fitness.sv
module pfsel_fitness #(
    parameter int CNT_W     = 16,
    parameter int CYC_W     = 24,
    parameter int MISS_K    = 4,
    parameter int BW_THRESH = 32,
    parameter int MW        = 25,
    parameter int FIT_W     = 27
) (
    input  logic [CNT_W:0]           hits_i,
    input  logic [CNT_W:0]           late_i,
    input  logic [CNT_W:0]           misses_i,
    input  logic [CYC_W:0]           cycles_i,
    output logic signed [FIT_W-1:0]  fit_o
);

    logic [MW-1:0] load;
    logic [MW-1:0] budget;
    logic [MW-1:0] pen;

    always_comb begin
        load   = MW'(misses_i) * MW'(MISS_K);
        budget = MW'(cycles_i) / MW'(BW_THRESH);
        pen    = (load > budget) ? (load - budget) : '0;
        fit_o  = $signed(FIT_W'(hits_i)) - $signed(FIT_W'(late_i))
               - $signed(FIT_W'(pen));
    end

    // R4
    always_comb begin
        pen_bound_chk: assert (pen <= load);
    end

endmodule

// File: rtl/pfsel_cfg_rng.sv
module pfsel_cfg_rng
    import pfsel_pkg::*;
#(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    advance_i,
    output pf_cfg_t shadow_o
);

    localparam logic [15:0] SEED_SAFE = (SEED == 16'h0) ? 16'h0001 : SEED;

    logic [15:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (advance_i) lfsr_d = lfsr_next(lfsr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED_SAFE;
        else        lfsr_q <= lfsr_d;
    end

    assign shadow_o = cfg_from_rand(lfsr_q);

    // R7
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0);

    // R7
    cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(shadow_o.degree) <= DEG_MAX) && (32'(shadow_o.distance) <= DIST_MAX)
        && (32'(shadow_o.region) < REGION_CODES));

    // R2
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(shadow_o));

endmodule

// File: rtl/pfsel_top.sv
module pfsel_top
    import pfsel_pkg::*;
#(
    parameter int          WINDOW_MISSES = 2000,
    parameter int          NEED_WINS     = 1,
    parameter int          MISS_K        = 4,
    parameter int          BW_THRESH     = 32,
    parameter int          CNT_W         = 16,
    parameter int          CYC_W         = 24,
    parameter logic [15:0] SEED          = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              real_hit,
    input  logic              real_late,
    input  logic              real_miss,
    input  logic              shadow_hit,
    input  logic              shadow_late,
    input  logic              shadow_miss,
    output logic [DEG_W-1:0]  live_degree,
    output logic [DIST_W-1:0] live_distance,
    output logic [REG_W-1:0]  live_region,
    output logic [DEG_W-1:0]  shadow_degree,
    output logic [DIST_W-1:0] shadow_distance,
    output logic [REG_W-1:0]  shadow_region
);

    localparam int WIN_W = $clog2(WINDOW_MISSES + 1);
    localparam int STK_W = $clog2(NEED_WINS + 1);
    localparam int KW    = $clog2(MISS_K + 1);
    localparam int PW    = CNT_W + 1 + KW;
    localparam int MW    = (PW > CYC_W + 1) ? PW : CYC_W + 1;
    localparam int FIT_W = MW + 2;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [CYC_W-1:0] cyc;
        logic [STK_W-1:0] streak;
        pf_cfg_t          live;
    } state_t;

    state_t st_d, st_q;

    // side 0 = real directory, side 1 = shadow directory
    logic [1:0] hit_v, late_v, miss_v;
    assign hit_v  = {shadow_hit,  real_hit};
    assign late_v = {shadow_late, real_late};
    assign miss_v = {shadow_miss, real_miss};

    logic [CNT_W:0]          hit_tot  [2];
    logic [CNT_W:0]          late_tot [2];
    logic [CNT_W:0]          miss_tot [2];
    logic signed [FIT_W-1:0] fit      [2];
    logic [CYC_W:0]          cyc_tot;
    logic                    eval;
    logic                    shadow_better;
    logic                    adopt;
    logic [STK_W:0]          streak_inc;
    pf_cfg_t                 shadow_cfg;

    assign cyc_tot = {1'b0, st_q.cyc} + (CYC_W+1)'(1);
    assign eval    = real_miss && (st_q.win == WIN_W'(WINDOW_MISSES - 1));

    for (genvar s = 0; s < 2; s++) begin : g_side
        pfsel_evt_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear_i    (eval),
            .hit_i      (hit_v[s]),
            .late_i     (late_v[s]),
            .miss_i     (miss_v[s]),
            .hit_tot_o  (hit_tot[s]),
            .late_tot_o (late_tot[s]),
            .miss_tot_o (miss_tot[s])
        );

        pfsel_fitness #(
            .CNT_W     (CNT_W),
            .CYC_W     (CYC_W),
            .MISS_K    (MISS_K),
            .BW_THRESH (BW_THRESH),
            .MW        (MW),
            .FIT_W     (FIT_W)
        ) u_fit (
            .hits_i   (hit_tot[s]),
            .late_i   (late_tot[s]),
            .misses_i (miss_tot[s]),
            .cycles_i (cyc_tot),
            .fit_o    (fit[s])
        );
    end

    pfsel_cfg_rng #(.SEED(SEED)) u_rng (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (eval),
        .shadow_o  (shadow_cfg)
    );

    always_comb begin
        st_d          = st_q;
        shadow_better = fit[1] > fit[0];
        streak_inc    = {1'b0, st_q.streak} + (STK_W+1)'(1);
        adopt         = eval && shadow_better
                        && (streak_inc >= (STK_W+1)'(NEED_WINS));
        if (eval) begin
            st_d.win = '0;
            st_d.cyc = '0;
            if (adopt) begin
                st_d.live   = shadow_cfg;
                st_d.streak = '0;
            end else if (shadow_better) begin
                st_d.streak = streak_inc[STK_W-1:0];
            end else begin
                st_d.streak = '0;
            end
        end else begin
            if (real_miss)   st_d.win = st_q.win + 1'b1;
            if (!(&st_q.cyc)) st_d.cyc = st_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_degree     = st_q.live.degree;
    assign live_distance   = st_q.live.distance;
    assign live_region     = st_q.live.region;
    assign shadow_degree   = shadow_cfg.degree;
    assign shadow_distance = shadow_cfg.distance;
    assign shadow_region   = shadow_cfg.region;

    // R2
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> $stable(st_q.live));

    // R2
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.win) < WINDOW_MISSES);

    // R6
    streak_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.streak) < NEED_WINS);

    // R5
    loss_keeps_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !(fit[1] > fit[0])) |=> $stable(st_q.live));

endmodule

// File: tb/tb_pfsel_top.sv
`timescale 1ns/1ps
module tb_pfsel_top;

    localparam int          WIN  = 4;
    localparam int          NEED = 2;
    localparam int          KMUL = 4;
    localparam int          THR  = 8;
    localparam logic [15:0] SEED = 16'hACE1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic real_hit = 0, real_late = 0, real_miss = 0;
    logic shadow_hit = 0, shadow_late = 0, shadow_miss = 0;
    logic [4:0] live_degree, live_distance, shadow_degree, shadow_distance;
    logic [3:0] live_region, shadow_region;

    always #2.5 clk = ~clk;

    pfsel_top #(
        .WINDOW_MISSES (WIN),
        .NEED_WINS     (NEED),
        .MISS_K        (KMUL),
        .BW_THRESH     (THR),
        .SEED          (SEED)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .real_hit(real_hit), .real_late(real_late), .real_miss(real_miss),
        .shadow_hit(shadow_hit), .shadow_late(shadow_late), .shadow_miss(shadow_miss),
        .live_degree(live_degree), .live_distance(live_distance), .live_region(live_region),
        .shadow_degree(shadow_degree), .shadow_distance(shadow_distance),
        .shadow_region(shadow_region)
    );

    typedef struct {
        int    ld, lt, lr, sd, st, sr;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    exp_t  cur;
    int    n_chk = 0, n_fail = 0;
    bit    finished = 0;
    string phase = "R1";

    // reference model state
    int          m_h[2], m_l[2], m_m[2];
    int          m_cyc, m_win, m_streak;
    logic [15:0] m_lfsr;

    function automatic logic [15:0] adv(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction

    function automatic void draw(input logic [15:0] s, output int d, output int t, output int r);
        d = int'(s[4:0]) % 17;
        t = int'(s[9:5]) % 17;
        r = int'(s[13:10]) % 11;
    endfunction

    function automatic longint fitness(input int s);
        longint load, bud, pen;
        load = longint'(m_m[s]) * KMUL;
        bud  = longint'(m_cyc) / THR;
        pen  = (load > bud) ? load - bud : 0;
        return longint'(m_h[s]) - longint'(m_l[s]) - pen;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input exp_t e, input string tag);
        chk(tag, "live_degree",     int'(live_degree),     e.ld);
        chk(tag, "live_distance",   int'(live_distance),   e.lt);
        chk(tag, "live_region",     int'(live_region),     e.lr);
        chk(tag, "shadow_degree",   int'(shadow_degree),   e.sd);
        chk(tag, "shadow_distance", int'(shadow_distance), e.st);
        chk(tag, "shadow_region",   int'(shadow_region),   e.sr);
    endtask

    // driver: one clock cycle of events, model updated, expectation pushed
    task automatic step(input bit rh, input bit rl, input bit rm,
                        input bit sh, input bit sl, input bit sm);
        longint fr, fs;
        real_hit = rh; real_late = rl; real_miss = rm;
        shadow_hit = sh; shadow_late = sl; shadow_miss = sm;
        m_cyc++;
        m_h[0] += int'(rh); m_l[0] += int'(rl); m_m[0] += int'(rm);
        m_h[1] += int'(sh); m_l[1] += int'(sl); m_m[1] += int'(sm);
        if (rm) m_win++;
        if (m_win == WIN) begin
            fr = fitness(0);
            fs = fitness(1);
            if (fs > fr) begin
                m_streak++;
                if (m_streak >= NEED) begin
                    cur.ld = cur.sd; cur.lt = cur.st; cur.lr = cur.sr;
                    m_streak = 0;
                end
            end else begin
                m_streak = 0;
            end
            m_lfsr = adv(m_lfsr);
            draw(m_lfsr, cur.sd, cur.st, cur.sr);
            cur.tag = phase;
            sb_q.push_back(cur);
            for (int s = 0; s < 2; s++) begin
                m_h[s] = 0; m_l[s] = 0; m_m[s] = 0;
            end
            m_cyc = 0;
            m_win = 0;
        end
        @(negedge clk);
    endtask

    task automatic window4(input bit rh, input bit rl, input bit sh,
                           input bit sl, input bit sm);
        for (int i = 0; i < WIN; i++) step(rh, rl, 1'b1, sh, sl, sm);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: pop expected results as the design produces them
    exp_t obs;
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                obs = sb_q.pop_front();
                check_all(obs, obs.tag);
            end else begin
                // R2: nothing moves between evaluations
                check_all(cur, "R2");
            end
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        m_lfsr = SEED;
        for (int s = 0; s < 2; s++) begin
            m_h[s] = 0; m_l[s] = 0; m_m[s] = 0;
        end
        m_cyc = 0; m_win = 0; m_streak = 0;
        cur.ld = 0; cur.lt = 0; cur.lr = 0;
        draw(m_lfsr, cur.sd, cur.st, cur.sr);
        cur.tag = "R1";

        repeat (3) @(negedge clk);
        // R1: reset state
        check_all(cur, "R1");
        rst_n = 1'b1;

        // R7: shadow wins once, no adoption yet, fresh draw
        phase = "R7";
        window4(0, 0, 1, 0, 0);
        // R5: second consecutive win adopts
        phase = "R5";
        window4(0, 0, 1, 0, 0);

        // R4: sparse misses, penalty clamps to zero, tie is a loss (R5)
        phase = "R4";
        for (int i = 0; i < 160; i++) step(0, 0, (i % 40) == 39, 0, 0, 0);

        // R6: win, loss by tie, win -> no adoption, then win -> adoption
        phase = "R6";
        window4(0, 0, 1, 0, 0);
        window4(0, 0, 0, 0, 1);
        window4(0, 0, 1, 0, 0);
        phase = "R5";
        window4(0, 0, 1, 0, 0);

        // R3: late prefetches and hits on the evaluation cycle count
        phase = "R3";
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 1, 0);
        step(0, 0, 1, 1, 0, 0);
        window4(1, 1, 1, 0, 1);
        step(0, 0, 0, 1, 1, 1);
        window4(0, 0, 0, 1, 0);

        // R8: random traffic, every window scored from zero
        phase = "R8";
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
                 ($urandom % 2) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0);
        end

        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        finish_run();
    end

endmodule